// File: doc/BRIEF.md
# Programmable Square Wave Timer Output

This block produces a square wave on a single output pin and runs from the bus clock. A fixed prescaler turns the bus clock into slow count ticks. A timer register holds a reload count and an operating mode. When the mode selects toggling, the pin level inverts once every (count + 1) ticks. Software can time the resulting wave with its own clock and so work out the frequency of the bus clock.

Software writes the timer register through a small register port. It can read the live output level back from the same register at any time. A second register holds a direction bit and an enable bit, and the pin is driven only when both are set. Writing the timer register restarts the timing from a clean state. Writing it with all zeros returns the block to the state it has after power-on.

Top module: `sqwave_timer`

## Requirements
- R1: After reset, rdData reads 0, pinOe is 0 and pinOut is 0.
- R2: One count tick lasts PRESCALE bus clocks (520 by default). With count 0 in toggle mode, the level first inverts exactly PRESCALE clocks after the timer write edge.
- R3: With mode 7, the level inverts every (count+1)*PRESCALE clocks, so a full period lasts 2*(count+1)*PRESCALE clocks.
- R4: Any mode value other than 7 holds the level and never toggles it.
- R5: A timer register write (wrSel=0) clears the prescaler and the tick counter and sets the level low. The timing then restarts from that write.
- R6: Writing all zeros to the timer register returns the block to its power-on state: rdData reads 0, the level is low, and it stays low.
- R7: pinOe is 1 only when bit 0 (direction) and bit 1 (enable) of the last pin-control write (wrSel=1) are both 1. Otherwise pinOe is 0 and pinOut is 0. Pin-control writes leave the timer untouched.
- R8: rdData reads count in bits [15:0], mode in [18:16], the diagnostic bit in [19] and the live level in [20], with all higher bits 0. The diagnostic bit is stored and read back but has no effect on timing.
- R9: When pinOe is 1, pinOut equals the live level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the timer register, 1 selects the pin-control register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Timer register readback, including the live level |
| pinOut | output | 1 | Square wave output, gated by the drive enable |
| pinOe | output | 1 | Pin drive enable |

## Verification
The embedded properties check several behaviours on every cycle:
- the prescaler and tick counter stay in range;
- the level changes only on a tick that ends a count span;
- the level is frozen outside toggle mode;
- a timer write clears the timing state;
- the pin stays quiet without its drive enable.

The exact toggle spacing for several count values can only be shown by the bench scenarios, which measure it in bus clocks. The same holds for restarting the timing with a write in the middle of a period, for returning to the power-on state after a zero write, and for the readback layout.

// File: rtl/sqwave_pkg.sv
`timescale 1ns/1ps
package sqwave_pkg;
  localparam int COUNT_W     = 16;
  localparam int MODE_W      = 3;
  localparam int COUNT_LSB   = 0;
  localparam int MODE_LSB    = COUNT_LSB + COUNT_W;
  localparam int DIAG_BIT    = MODE_LSB + MODE_W;
  localparam int LEVEL_BIT   = DIAG_BIT + 1;
  localparam int FIELDS_W    = LEVEL_BIT + 1;
  localparam int PIN_DIR_BIT = 0;
  localparam int PIN_EN_BIT  = 1;
  localparam logic [MODE_W-1:0] TOGGLE_MODE = 3'd7;

  typedef struct packed {
    logic               diag;
    logic [MODE_W-1:0]  mode;
    logic [COUNT_W-1:0] count;
  } cfg_t;

  typedef struct packed {
    logic restart;
    logic run;
  } strobe_t;
endpackage

// File: rtl/sqwave_ctrl.sv
`timescale 1ns/1ps
module sqwave_ctrl
  import sqwave_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              cfg,
  output strobe_t           strobe,
  output logic              driveEn
);
  logic dirBit;
  logic enBit;
  logic cfgWrite;
  logic pinWrite;

  assign cfgWrite = wrEn && !wrSel;
  assign pinWrite = wrEn && wrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWrite) begin
      cfg.count <= wrData[COUNT_LSB +: COUNT_W];
      cfg.mode  <= wrData[MODE_LSB +: MODE_W];
      cfg.diag  <= wrData[DIAG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirBit <= 1'b0;
      enBit  <= 1'b0;
    end else if (pinWrite) begin
      dirBit <= wrData[PIN_DIR_BIT];
      enBit  <= wrData[PIN_EN_BIT];
    end
  end

  assign strobe.restart = cfgWrite;
  assign strobe.run     = (cfg.mode == TOGGLE_MODE) && !cfgWrite;
  assign driveEn        = dirBit && enBit;

  // R7: pin-control writes never disturb the timer configuration
  assert_pin_write_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> $stable(cfg));
endmodule

// File: rtl/sqwave_dp.sv
`timescale 1ns/1ps
module sqwave_dp
  import sqwave_pkg::*;
#(
  parameter int PRESCALE = 520
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [COUNT_W-1:0] count,
  output logic               level
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]   presc;
  logic               tick;
  logic [COUNT_W-1:0] ticks;
  logic               spanEnd;

  generate
    if (PRESCALE > 1) begin : gPresc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               presc <= '0;
        else if (strobe.restart) presc <= '0;
        else if (strobe.run)     presc <= (presc == PRE_LAST) ? '0 : presc + 1'b1;
      end
      assign tick = strobe.run && (presc == PRE_LAST);
    end else begin : gNoPresc
      assign presc = '0;
      assign tick  = strobe.run;
    end
  endgenerate

  assign spanEnd = tick && (ticks == count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ticks <= '0;
    else if (strobe.restart) ticks <= '0;
    else if (tick)           ticks <= (ticks == count) ? '0 : ticks + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               level <= 1'b0;
    else if (strobe.restart) level <= 1'b0;
    else if (spanEnd)        level <= ~level;
  end

  // R2: prescaler never leaves its range
  assert_presc_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    presc <= PRE_LAST);

  // R3: tick counter never passes the reload count
  assert_ticks_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    ticks <= count);

  // R2: the level only changes on the last prescaler step
  assert_toggle_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.restart) && (level != $past(level))) |-> ($past(presc) == PRE_LAST));

  // R4: outside toggle mode the level is frozen
  assert_hold_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> $stable(level));

  // R5: a timer write clears timing state and drops the level
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (!level && presc == '0 && ticks == '0));
endmodule

// File: rtl/sqwave_timer.sv
`timescale 1ns/1ps
module sqwave_timer
  import sqwave_pkg::*;
#(
  parameter int PRESCALE = 520,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pinOut,
  output logic              pinOe
);
  cfg_t    cfg;
  strobe_t strobe;
  logic    level;
  logic    driveEn;

  sqwave_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .cfg     (cfg),
    .strobe  (strobe),
    .driveEn (driveEn)
  );

  sqwave_dp #(.PRESCALE(PRESCALE)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (cfg.count),
    .level  (level)
  );

  assign rdData = DATA_W'({level, cfg.diag, cfg.mode, cfg.count});
  assign pinOe  = driveEn;
  assign pinOut = level && driveEn;

  // R7: no output activity without drive enable
  assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinOut);

  // R9: driven pin follows the live level shown in readback
  assert_pin_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> (pinOut == rdData[LEVEL_BIT]));
endmodule

// File: tb/tb_sqwave_timer.sv
`timescale 1ns/1ps
module tb_sqwave_timer;
  localparam int PRESCALE = 520;
  localparam int DATA_W   = 32;
  localparam int NVEC     = 4;

  localparam logic [15:0] V_COUNT [NVEC] = '{16'd0, 16'd1, 16'd2, 16'd5};
  localparam logic [2:0]  V_MODE  [NVEC] = '{3'd7, 3'd7, 3'd7, 3'd3};
  localparam logic        V_DIAG  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [1:0]  V_PIN   [NVEC] = '{2'b11, 2'b01, 2'b10, 2'b11};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              pinOut;
  logic              pinOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sqwave_timer #(.PRESCALE(PRESCALE), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [DATA_W-1:0] cfgWord(logic [15:0] c, logic [2:0] m, logic d, logic lvl);
    return DATA_W'({lvl, d, m, c});
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    waitCycles(150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    // R1: reset state
    chk("R1 rdData", rdData, '0);
    chk("R1 pinOe", DATA_W'(pinOe), '0);
    chk("R1 pinOut", DATA_W'(pinOut), '0);
    rstN = 1'b1;
    waitCycles(2);
    chk("R1 after release", rdData, '0);

    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic drv;
      n = (int'(V_COUNT[v]) + 1) * PRESCALE;
      drv = (V_PIN[v] == 2'b11);
      writeReg(1'b1, DATA_W'(V_PIN[v]));
      writeReg(1'b0, DATA_W'({V_DIAG[v], V_MODE[v], V_COUNT[v]}));
      // R8: readback layout, R5: level low after write
      chk("R8 readback", rdData, cfgWord(V_COUNT[v], V_MODE[v], V_DIAG[v], 1'b0));
      chk("R7 pinOe", DATA_W'(pinOe), DATA_W'(drv));
      if (V_MODE[v] == 3'd7) begin
        waitCycles(n - 1);
        chk("R2/R3 before first toggle", DATA_W'(rdData[20]), 0);
        waitCycles(1);
        chk("R3 first toggle", DATA_W'(rdData[20]), 1);
        chk("R9 pinOut driven level", DATA_W'(pinOut), DATA_W'(drv));
        waitCycles(n - 1);
        chk("R3 hold high span", DATA_W'(rdData[20]), 1);
        waitCycles(1);
        chk("R3 second toggle", DATA_W'(rdData[20]), 0);
      end else begin
        waitCycles(2 * PRESCALE + 5);
        chk("R4 non-toggle mode holds", rdData, cfgWord(V_COUNT[v], V_MODE[v], V_DIAG[v], 1'b0));
        chk("R4 pin quiet", DATA_W'(pinOut), 0);
      end
    end

    // R5: rewrite mid-span restarts timing; level goes low again
    writeReg(1'b1, 32'h3);
    writeReg(1'b0, cfgWord(16'd0, 3'd7, 1'b0, 1'b0));
    waitCycles(PRESCALE + 10);
    chk("R5 high before rewrite", DATA_W'(rdData[20]), 1);
    writeReg(1'b0, cfgWord(16'd0, 3'd7, 1'b0, 1'b0));
    chk("R5 level low after rewrite", DATA_W'(rdData[20]), 0);
    waitCycles(PRESCALE - 1);
    chk("R5 no early toggle", DATA_W'(rdData[20]), 0);
    waitCycles(1);
    chk("R5 toggle timed from rewrite", DATA_W'(rdData[20]), 1);

    // R7: pin-control write does not restart the timer
    writeReg(1'b1, 32'h1);
    chk("R7 level kept by pin write", DATA_W'(rdData[20]), 1);
    chk("R7 drive off dir only", DATA_W'(pinOe), 0);
    chk("R7 pinOut gated", DATA_W'(pinOut), 0);
    writeReg(1'b1, 32'h3);
    chk("R9 pinOut follows level", DATA_W'(pinOut), 1);

    // R6: zero write returns to power-on state
    writeReg(1'b0, '0);
    chk("R6 rdData zero", rdData, '0);
    chk("R6 pinOut low", DATA_W'(pinOut), 0);
    waitCycles(2 * PRESCALE + 20);
    chk("R6 stays idle", rdData, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule